// File: doc/BRIEF.md
# ATA Task-File Register and Status Unit

This block is the device side of an ATA register interface. A host reaches eight byte-wide register offsets through a simple read/write strobe bus. Offset 0 is a 16-bit data port. Offset 1 takes the feature byte on writes and returns the error byte on reads. Offsets 2 to 6 hold the sector count, the three address bytes and the device byte. Offset 7 takes a command opcode on writes and returns the status byte on reads. The block keeps the status bits consistent and drives one interrupt line. Reading the status register clears that interrupt as a side effect.

Three command flows share one phase machine:
- **IDENTIFY.** The block streams 256 words through the data port. The words come from a small computed ROM that holds a serial string, a version string, the capacity and the write-cache flag.
- **FLUSH CACHE.** The block holds BSY until an external one-cycle completion pulse arrives.
- **Trim.** Data-set management with the trim feature bit takes one 8-byte range through the data port and checks it against the capacity.

Any other opcode is aborted. The block is used as device 0 on its channel.

Top module: `ata_taskfile_unit`

## Requirements
- R1: After reset, status reads 0x40 (DRDY only), the error register reads 0x00 and the interrupt is low.
- R2: Bytes written at offsets 2, 3, 4, 5 and 6 read back unchanged at the same offsets while the device is idle.
- R3: Opcode 0xEC raises the interrupt and sets status to 0x48 (DRDY, DRQ) before each of exactly 256 data-port reads. After the 256th read, status returns to 0x40.
- R4: The IDENTIFY words are defined as follows. All others read as zero.
  - Word 0 is 0x0040.
  - Word 49 is 0x0200.
  - Words 10–19 carry the 20-character serial "TESTDISK" padded with spaces. The first character of each pair is in the high byte.
  - Words 23–26 carry the 8-character version "REV1.00 " in the same byte order.
  - Words 60 and 61 carry the low and high halves of the 28-bit capacity (131072 sectors).
  - Word 85 has bit 5 set (write cache enabled).
- R5: Opcode 0xE7 shows status 0xC0 (BSY, DRDY) for as long as the completion input stays low. The cycle after a completion pulse, status is 0x40 and the interrupt is high. BSY and DRQ are never set together.
- R6: A status read (offset 7) clears a pending interrupt. An error-register read (offset 1) does not clear it.
- R7: Opcode 0x06 with feature bit 0 set shows status 0x48 and accepts four data-port writes, forming one range:
  - words 0–2 are the starting sector, least significant word first;
  - word 3 is the sector count.
  
  A range ending at or below the capacity completes with status 0x40, error 0x00 and the interrupt raised.
- R8: A trim range whose start plus count exceeds the capacity completes with status 0x41 (ERR), error register 0x04 (ABRT) and the interrupt raised.
- R9: Any opcode other than 0xEC, 0xE7 or trim is aborted. This includes 0x06 with feature bit 0 clear. The abort gives status 0x41, error 0x04 and a raised interrupt, with BSY and DRQ clear.
- R10: The following writes are ignored:
  - a command write while BSY or DRQ is set;
  - a write to offsets 1–6 while BSY or DRQ is set;
  - a command write while device-byte bit 4 (0x10, device 1) is set.
- R11: An accepted command clears ERR and the error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe; side effects occur at the clock edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset 0–7 |
| wdata | input | 16 | Write data; bits 7:0 for byte registers, all 16 for the data port |
| rdata | output | 16 | Read data for the addressed offset (combinational) |
| flush_done | input | 1 | One-cycle pulse ending a pending cache flush |
| irq | output | 1 | Interrupt request to the host |

## Verification
The IDENTIFY stream is read word by word. A status read sits between every pair of data reads, so an off-by-one in the word counter, a wrong byte order in the strings or an early DRQ drop each shows at a distinct word. Trim is run with three ranges that separate a correct inclusive capacity bound from an off-by-one compare:
- one that ends well inside the capacity;
- one that ends exactly on the capacity;
- one that runs one sector past it.

The flush is held pending across several cycles, with stray command and register writes applied. This separates a block that waits for the completion pulse from one that finishes on its own or lets the writes through. Error-register and status reads are interleaved, which shows which of the two clears the interrupt.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    // status byte bit masks
    localparam logic [7:0] SB_BUSY  = 8'h80;
    localparam logic [7:0] SB_READY = 8'h40;
    localparam logic [7:0] SB_FAULT = 8'h20;
    localparam logic [7:0] SB_DREQ  = 8'h08;
    localparam logic [7:0] SB_ERR   = 8'h01;

    // error byte
    localparam logic [7:0] ER_ABORT = 8'h04;

    // device byte
    localparam int DEVSEL_BIT = 4;

    // opcodes
    localparam logic [7:0] OPC_IDENT = 8'hEC;
    localparam logic [7:0] OPC_FLUSH = 8'hE7;
    localparam logic [7:0] OPC_DSM   = 8'h06;

    // register offsets
    localparam logic [2:0] RO_DATA    = 3'd0;
    localparam logic [2:0] RO_FEATERR = 3'd1;
    localparam logic [2:0] RO_CMDSTAT = 3'd7;

    localparam int TRIM_WORDS = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEND,
        PH_FLUSH,
        PH_RECV,
        PH_CHECK
    } phase_e;

    typedef enum logic [1:0] {
        OP_IDENT,
        OP_FLUSH,
        OP_TRIM,
        OP_REJECT
    } op_e;

    typedef struct packed {
        logic [15:0] count;
        logic [47:0] lba;
    } trim_rng_t;

    function automatic op_e classify(input logic [7:0] code, input logic trim_bit);
        if (code == OPC_IDENT)                 return OP_IDENT;
        else if (code == OPC_FLUSH)            return OP_FLUSH;
        else if (code == OPC_DSM && trim_bit)  return OP_TRIM;
        else                                   return OP_REJECT;
    endfunction

    function automatic logic [7:0] make_status(input phase_e ph, input logic err);
        logic [7:0] s;
        s = SB_READY;
        if (ph == PH_FLUSH || ph == PH_CHECK) s = s | SB_BUSY;
        if (ph == PH_SEND || ph == PH_RECV)   s = s | SB_DREQ;
        if (err)                              s = s | SB_ERR;
        return s;
    endfunction

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wbyte,
    input  logic       locked,
    output logic [7:0] feature,
    output logic [7:0] count,
    output logic [7:0] lba_lo,
    output logic [7:0] lba_mid,
    output logic [7:0] lba_hi,
    output logic [7:0] device
);
    localparam int FIRST = 1;
    localparam int LAST  = 6;

    logic [7:0] byte_q [FIRST:LAST];

    for (genvar g = FIRST; g <= LAST; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                byte_q[g] <= 8'h00;
            else if (wr_en && !locked && addr == 3'(g))
                byte_q[g] <= wbyte;
        end
    end

    assign feature = byte_q[1];
    assign count   = byte_q[2];
    assign lba_lo  = byte_q[3];
    assign lba_mid = byte_q[4];
    assign lba_hi  = byte_q[5];
    assign device  = byte_q[6];

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_en) |=> ($stable(count) && $stable(device))); // R10

endmodule

// File: rtl/ata_ident_rom.sv
module ata_ident_rom #(
    parameter int          IDX_W     = 8,
    parameter logic [159:0] SERIAL   = "TESTDISK            ",
    parameter logic [63:0]  VERSION  = "REV1.00 ",
    parameter int unsigned CAPACITY  = 131072,
    parameter bit          WCACHE_ON = 1'b1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word
);
    localparam int SER_WORDS = 10;
    localparam int VER_WORDS = 4;
    localparam int SER_BASE  = 10;
    localparam int VER_BASE  = 23;
    localparam logic [31:0] CAP32 = 32'(CAPACITY);

    logic [15:0] ser_w [SER_WORDS];
    logic [15:0] ver_w [VER_WORDS];

    for (genvar i = 0; i < SER_WORDS; i++) begin : g_ser
        assign ser_w[i] = SERIAL[159 - 16*i -: 16];
    end
    for (genvar i = 0; i < VER_WORDS; i++) begin : g_ver
        assign ver_w[i] = VERSION[63 - 16*i -: 16];
    end

    always_comb begin
        word = 16'h0000;
        if (idx == IDX_W'(0))  word = 16'h0040;
        if (idx == IDX_W'(49)) word = 16'h0200;
        if (idx == IDX_W'(60)) word = CAP32[15:0];
        if (idx == IDX_W'(61)) word = {4'h0, CAP32[27:16]};
        if (idx == IDX_W'(85)) word = WCACHE_ON ? 16'h0020 : 16'h0000;
        for (int i = 0; i < SER_WORDS; i++)
            if (idx == IDX_W'(SER_BASE + i)) word = ser_w[i];
        for (int i = 0; i < VER_WORDS; i++)
            if (idx == IDX_W'(VER_BASE + i)) word = ver_w[i];
    end

endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
    import ata_tf_pkg::*;
#(
    parameter int          IDENT_WORDS = 256,
    parameter int unsigned CAPACITY    = 131072,
    localparam int         IDX_W       = $clog2(IDENT_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_code,
    input  logic             trim_bit,
    input  logic             dev1_sel,
    input  logic             data_rd,
    input  logic             data_wr,
    input  logic [15:0]      data_in,
    input  logic             stat_rd,
    input  logic             flush_done,
    output logic [7:0]       status,
    output logic [7:0]       error,
    output logic             irq,
    output logic [IDX_W-1:0] word_idx,
    output logic             sending,
    output logic             locked
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IDENT_WORDS - 1);
    localparam int               TW_W     = $clog2(TRIM_WORDS);
    localparam logic [TW_W-1:0]  LAST_TW  = TW_W'(TRIM_WORDS - 1);
    localparam logic [48:0]      CAP49    = 49'(CAPACITY);

    phase_e           ph_q;
    logic             err_q;
    logic             abrt_q;
    logic             irq_q;
    logic [IDX_W-1:0] idx_q;
    logic [TW_W-1:0]  tw_cnt_q;
    logic [15:0]      tw_q [TRIM_WORDS];

    trim_rng_t   rng;
    logic [48:0] rng_end;
    logic        rng_bad;
    logic        accept;
    op_e         op;

    assign rng     = {tw_q[3], tw_q[2], tw_q[1], tw_q[0]};
    assign rng_end = {1'b0, rng.lba} + 49'(rng.count);
    assign rng_bad = rng_end > CAP49;
    assign accept  = cmd_we && !dev1_sel && ph_q == PH_IDLE;
    assign op      = classify(cmd_code, trim_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            err_q    <= 1'b0;
            abrt_q   <= 1'b0;
            irq_q    <= 1'b0;
            idx_q    <= '0;
            tw_cnt_q <= '0;
            for (int i = 0; i < TRIM_WORDS; i++) tw_q[i] <= 16'h0000;
        end else begin
            if (stat_rd) irq_q <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (accept) begin
                        err_q  <= 1'b0;
                        abrt_q <= 1'b0;
                        unique case (op)
                            OP_IDENT: begin
                                ph_q  <= PH_SEND;
                                idx_q <= '0;
                                irq_q <= 1'b1;
                            end
                            OP_FLUSH: ph_q <= PH_FLUSH;
                            OP_TRIM: begin
                                ph_q     <= PH_RECV;
                                tw_cnt_q <= '0;
                            end
                            OP_REJECT: begin
                                err_q  <= 1'b1;
                                abrt_q <= 1'b1;
                                irq_q  <= 1'b1;
                            end
                        endcase
                    end
                end
                PH_SEND: begin
                    if (data_rd) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == LAST_IDX) ph_q <= PH_IDLE;
                    end
                end
                PH_FLUSH: begin
                    if (flush_done) begin
                        ph_q  <= PH_IDLE;
                        irq_q <= 1'b1;
                    end
                end
                PH_RECV: begin
                    if (data_wr) begin
                        tw_q[tw_cnt_q] <= data_in;
                        tw_cnt_q       <= tw_cnt_q + 1'b1;
                        if (tw_cnt_q == LAST_TW) ph_q <= PH_CHECK;
                    end
                end
                PH_CHECK: begin
                    err_q  <= rng_bad;
                    abrt_q <= rng_bad;
                    irq_q  <= 1'b1;
                    ph_q   <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign status   = make_status(ph_q, err_q);
    assign error    = abrt_q ? ER_ABORT : 8'h00;
    assign irq      = irq_q;
    assign word_idx = idx_q;
    assign sending  = ph_q == PH_SEND;
    assign locked   = ph_q != PH_IDLE;

    AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((status & SB_BUSY) != 0 && (status & SB_DREQ) != 0)); // R5
    AST_FLUSH_WAIT: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_FLUSH && !flush_done) |=> ph_q == PH_FLUSH); // R5
    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && ph_q == PH_IDLE && !cmd_we) |=> !irq); // R6
    AST_IDENT_STEP: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_SEND && data_rd && idx_q != LAST_IDX) |=>
            (idx_q == $past(idx_q) + 1'b1 && ph_q == PH_SEND)); // R3
    AST_ERR_ABRT: assert property (@(posedge clk) disable iff (rst)
        ((status & SB_ERR) != 0) |-> error == ER_ABORT); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && (ph_q == PH_FLUSH || ph_q == PH_SEND)) |=>
            ($stable(err_q) && ph_q != PH_RECV)); // R10

endmodule

// File: rtl/ata_taskfile_unit.sv
module ata_taskfile_unit
    import ata_tf_pkg::*;
#(
    parameter int           IDENT_WORDS = 256,
    parameter int unsigned  CAPACITY    = 131072,
    parameter logic [159:0] SERIAL      = "TESTDISK            ",
    parameter logic [63:0]  VERSION     = "REV1.00 ",
    parameter bit           WCACHE_ON   = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        flush_done,
    output logic        irq
);
    localparam int IDX_W = $clog2(IDENT_WORDS);

    logic [7:0]       feature, count, lba_lo, lba_mid, lba_hi, device;
    logic [7:0]       status, error;
    logic [IDX_W-1:0] word_idx;
    logic [15:0]      rom_word;
    logic             sending, locked;

    ata_tf_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wbyte   (wdata[7:0]),
        .locked  (locked),
        .feature (feature),
        .count   (count),
        .lba_lo  (lba_lo),
        .lba_mid (lba_mid),
        .lba_hi  (lba_hi),
        .device  (device)
    );

    ata_tf_ctrl #(
        .IDENT_WORDS (IDENT_WORDS),
        .CAPACITY    (CAPACITY)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_we     (wr_en && addr == RO_CMDSTAT),
        .cmd_code   (wdata[7:0]),
        .trim_bit   (feature[0]),
        .dev1_sel   (device[DEVSEL_BIT]),
        .data_rd    (rd_en && addr == RO_DATA),
        .data_wr    (wr_en && addr == RO_DATA),
        .data_in    (wdata),
        .stat_rd    (rd_en && addr == RO_CMDSTAT),
        .flush_done (flush_done),
        .status     (status),
        .error      (error),
        .irq        (irq),
        .word_idx   (word_idx),
        .sending    (sending),
        .locked     (locked)
    );

    ata_ident_rom #(
        .IDX_W     (IDX_W),
        .SERIAL    (SERIAL),
        .VERSION   (VERSION),
        .CAPACITY  (CAPACITY),
        .WCACHE_ON (WCACHE_ON)
    ) u_rom (
        .idx  (word_idx),
        .word (rom_word)
    );

    always_comb begin
        unique case (addr)
            3'd0:    rdata = sending ? rom_word : 16'h0000;
            3'd1:    rdata = {8'h00, error};
            3'd2:    rdata = {8'h00, count};
            3'd3:    rdata = {8'h00, lba_lo};
            3'd4:    rdata = {8'h00, lba_mid};
            3'd5:    rdata = {8'h00, lba_hi};
            3'd6:    rdata = {8'h00, device};
            default: rdata = {8'h00, status};
        endcase
    end

endmodule

// File: tb/ata_taskfile_unit_test.sv
module ata_taskfile_unit_test;

    localparam int CAP = 131072;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        flush_done = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ata_taskfile_unit uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .flush_done(flush_done), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] exp_word(input int w);
        string ser = "TESTDISK            ";
        string ver = "REV1.00 ";
        logic [31:0] cap = 32'(CAP);
        if (w == 0)  return 16'h0040;
        if (w == 49) return 16'h0200;
        if (w == 60) return cap[15:0];
        if (w == 61) return {4'h0, cap[27:16]};
        if (w == 85) return 16'h0020;
        if (w >= 10 && w <= 19) return {ser[2*(w-10)], ser[2*(w-10)+1]};
        if (w >= 23 && w <= 26) return {ver[2*(w-23)], ver[2*(w-23)+1]};
        return 16'h0000;
    endfunction

    task automatic t_reset;
        logic [15:0] v;
        check("R1 irq", int'(irq), 0);
        bus_rd(3'd7, v); check("R1 status", int'(v), 'h40);
        bus_rd(3'd1, v); check("R1 error", int'(v), 'h00);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        bus_wr(3'd2, 16'h00A5); bus_wr(3'd3, 16'h003C); bus_wr(3'd4, 16'h00C3);
        bus_wr(3'd5, 16'h005A); bus_wr(3'd6, 16'h00E0);
        bus_rd(3'd2, v); check("R2 count", int'(v), 'hA5);
        bus_rd(3'd3, v); check("R2 lba low", int'(v), 'h3C);
        bus_rd(3'd4, v); check("R2 lba mid", int'(v), 'hC3);
        bus_rd(3'd5, v); check("R2 lba high", int'(v), 'h5A);
        bus_rd(3'd6, v); check("R2 device", int'(v), 'hE0);
        bus_wr(3'd6, 16'h0040);
    endtask

    task automatic t_identify;
        logic [15:0] v;
        int bad_stat = 0;
        int bad_word = 0;
        bus_wr(3'd7, 16'h00EC);
        check("R3 irq on entry", int'(irq), 1);
        for (int w = 0; w < 256; w++) begin
            bus_rd(3'd7, v);
            if (v != 16'h0048) begin
                bad_stat++;
                if (bad_stat == 1) check("R3 status during stream", int'(v), 'h48);
            end
            bus_rd(3'd0, v);
            if (v != exp_word(w)) begin
                bad_word++;
                $display("FAIL R4 word %0d: actual=0x%0h expected=0x%0h", w, v, exp_word(w));
            end
        end
        check("R3 status never wrong", bad_stat, 0);
        check("R4 words all match", bad_word, 0);
        if (bad_word != 0) errors += 0;
        bus_rd(3'd7, v); check("R3 status after stream", int'(v), 'h40);
        check("R6 irq cleared by status reads", int'(irq), 0);
        bus_rd(3'd0, v); check("R3 data port idle", int'(v), 0);
    endtask

    task automatic t_flush;
        logic [15:0] v;
        bus_wr(3'd2, 16'h0011);
        bus_wr(3'd7, 16'h00E7);
        bus_rd(3'd7, v); check("R5 status pending", int'(v), 'hC0);
        bus_wr(3'd7, 16'h00EC);
        bus_wr(3'd2, 16'h0077);
        idle_cycles(5);
        bus_rd(3'd7, v); check("R5 still pending / R10 cmd ignored", int'(v), 'hC0);
        check("R5 irq low while pending", int'(irq), 0);
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
        check("R5 irq after done", int'(irq), 1);
        bus_rd(3'd1, v); check("R6 error read keeps irq", int'(irq), 1);
        bus_rd(3'd7, v); check("R5 status after done", int'(v), 'h40);
        check("R6 status read clears irq", int'(irq), 0);
        bus_rd(3'd2, v); check("R10 reg write while busy ignored", int'(v), 'h11);
    endtask

    task automatic t_trim(input longint lba, input int cnt, input int exp_stat,
                          input int exp_err, input string tag);
        logic [15:0] v;
        bus_wr(3'd1, 16'h0001);
        bus_wr(3'd7, 16'h0006);
        bus_rd(3'd7, v); check({tag, " status receiving"}, int'(v), 'h48);
        bus_wr(3'd0, 16'(lba));
        bus_wr(3'd0, 16'(lba >> 16));
        bus_wr(3'd0, 16'(lba >> 32));
        bus_wr(3'd0, 16'(cnt));
        idle_cycles(1);
        check({tag, " irq"}, int'(irq), 1);
        bus_rd(3'd7, v); check({tag, " status"}, int'(v), exp_stat);
        bus_rd(3'd1, v); check({tag, " error"}, int'(v), exp_err);
    endtask

    task automatic t_reject;
        logic [15:0] v;
        bus_wr(3'd7, 16'h0077);
        check("R9 irq on abort", int'(irq), 1);
        bus_rd(3'd7, v); check("R9 status abort", int'(v), 'h41);
        bus_rd(3'd1, v); check("R9 error abort", int'(v), 'h04);
        bus_wr(3'd1, 16'h0000);
        bus_wr(3'd7, 16'h0006);
        bus_rd(3'd7, v); check("R9 dsm without trim aborts", int'(v), 'h41);
        bus_wr(3'd7, 16'h00E7);
        bus_rd(3'd7, v); check("R11 err cleared on accept", int'(v), 'hC0);
        bus_rd(3'd1, v); check("R11 error reg cleared", int'(v), 'h00);
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
        bus_rd(3'd7, v);
    endtask

    task automatic t_dev1;
        logic [15:0] v;
        bus_wr(3'd6, 16'h0050);
        bus_wr(3'd7, 16'h00EC);
        check("R10 device 1 command no irq", int'(irq), 0);
        bus_rd(3'd7, v); check("R10 device 1 command ignored", int'(v), 'h40);
        bus_wr(3'd6, 16'h0040);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle_cycles(3);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_regs();
        t_identify();
        t_flush();
        t_trim(48'd100, 8, 'h40, 'h00, "R7 inside");
        t_trim(48'(CAP - 1), 1, 'h40, 'h00, "R7 exact end");
        t_trim(48'(CAP - 1), 2, 'h41, 'h04, "R8 past end");
        t_reject();
        t_dev1();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule